// File: doc/BRIEF.md
# Circular Hardware Return Stack

This block keeps the return addresses of a small microcontroller core. When a subroutine call executes, or an interrupt diverts the program flow, the core's program counter logic pulses `push_req` with the address to save. When one of the three return-type instructions executes (plain return, return with a literal, return from interrupt), the core pulses `pop_req`. One cycle later the block presents the saved address on `ret_addr` and marks it with a single-cycle `ret_valid`. Instruction decode and program counter selection stay in the core.

The storage holds eight 13-bit entries by default. It is addressed by a hidden pointer and lies outside both program and data space. Software cannot read or write the pointer, and there are no full, empty, overflow or underflow flags. The storage is a ring. A push beyond the depth quietly overwrites the oldest entry. A pop past the bottom wraps and returns whatever entry the wrapped pointer selects.

Both strobes are plain control pins with no back-pressure. The stack accepts every strobe in the cycle it is asserted and never stalls the core. The `ret_addr`/`ret_valid` pair is a valid-only stream: the consumer must take the address in the cycle `ret_valid` is high, because nothing holds it for a later cycle.

Top module: `ret_stack_ring`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ret_valid` is 0, `ret_addr` is 0 and the hidden pointer is at entry 0.
- R2: A push writes `push_addr` into the entry the pointer selects, then advances the pointer by one. A pop first steps the pointer back by one, then returns that entry, so pops return pushed addresses in last-in, first-out order.
- R3: A pop sampled on a clock edge makes `ret_valid` high for exactly the following cycle and puts the popped address on `ret_addr` in that cycle. In every cycle without `ret_valid`, `ret_addr` keeps its previous value, and no `ret_valid` appears without a pop.
- R4: The pointer wraps forward modulo the depth. With a depth of 8, the ninth push in a row overwrites the first pushed address and the tenth overwrites the second. No flag reports this.
- R5: A pop with the pointer at entry 0 wraps the pointer to the last entry (entry 7 for a depth of 8) and returns its contents. No flag reports this.
- R6: If `push_req` and `pop_req` are high in the same cycle, only the push takes effect and no `ret_valid` follows.
- R7: Reset clears only the pointer. Entry contents written before a reset are still returned by pops after it.
- R8: All 13 address bits pass through unchanged, including the all-ones value 0x1FFF and the single top bit 0x1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Save `push_addr` (call or interrupt entry) |
| push_addr | input | 13 | Return address to save |
| pop_req | input | 1 | Retrieve the most recent address (any return) |
| ret_addr | output | 13 | Popped address, held between pops |
| ret_valid | output | 1 | High for one cycle when `ret_addr` carries a new pop result |

## Verification
The assertions rely on the core treating the strobes as single-cycle requests sampled on the rising edge. They also rely on the core never reading `ret_addr` outside the cycle marked by `ret_valid`. They expect reset to be released only between edges. The property on written entries assumes that `push_addr` is a known value whenever `push_req` is high. The bench drives every input on the falling edge, keeps `push_addr` defined whenever it pushes, and issues underflowing pops only once every entry has been written. As a result, no pop returns uninitialised storage.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  localparam int unsigned RSTK_DEPTH = 8;
  localparam int unsigned RSTK_AW    = 13;

  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;

  // Push wins when both strobes show up together.
  function automatic stk_op_e stk_decode(input logic psh, input logic pp);
    if (psh)     return STK_PUSH;
    else if (pp) return STK_POP;
    else         return STK_IDLE;
  endfunction

endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = RSTK_DEPTH,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_e       op,
  output logic [PW-1:0] wr_idx,
  output logic [PW-1:0] rd_idx
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_inc;
  logic [PW-1:0] ptr_dec;

  always_comb begin
    ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
    ptr_dec = (ptr_q == '0) ? LAST : ptr_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      unique case (op)
        STK_PUSH: ptr_q <= ptr_inc;
        STK_POP:  ptr_q <= ptr_dec;
        default:  ptr_q <= ptr_q;
      endcase
    end
  end

  assign wr_idx = ptr_q;
  assign rd_idx = ptr_dec;

  // R4
  wrap_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_PUSH && ptr_q == LAST) |=> ptr_q == '0);

  // R5
  wrap_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_POP && ptr_q == '0) |=> ptr_q == LAST);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_IDLE) |=> $stable(ptr_q));

endmodule

// File: rtl/rstk_mem.sv
module rstk_mem
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = RSTK_DEPTH,
  parameter int unsigned AW    = RSTK_AW,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [AW-1:0] rd_data
);

  logic [AW-1:0] slot [DEPTH];

  // Entries carry no reset: only the pointer is cleared.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == PW'(g));
    always_ff @(posedge clk) begin
      if (hit) slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];

  // R2
  slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/ret_stack_ring.sv
module ret_stack_ring
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = RSTK_DEPTH,
  parameter int unsigned AW    = RSTK_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [AW-1:0] push_addr,
  input  logic          pop_req,
  output logic [AW-1:0] ret_addr,
  output logic          ret_valid
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  stk_op_e       op;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] rd_idx;
  logic [AW-1:0] rd_data;

  assign op = stk_decode(push_req, pop_req);

  rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx)
  );

  rstk_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (op == STK_PUSH),
    .wr_idx  (wr_idx),
    .wr_data (push_addr),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_addr  <= '0;
      ret_valid <= 1'b0;
    end else begin
      ret_valid <= (op == STK_POP);
      if (op == STK_POP) ret_addr <= rd_data;
    end
  end

  // R3
  pop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req) |=> ret_valid);

  // R3
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |-> $stable(ret_addr));

  // R6
  push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> !ret_valid);

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |-> (!ret_valid && ret_addr == '0));

endmodule

// File: tb/sim_ret_stack_ring.sv
`timescale 1ns/1ps
module sim_ret_stack_ring;

  localparam int AW = 13;
  localparam int DP = 8;

  typedef struct {
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_req = 1'b0;
  logic [AW-1:0] push_addr = '0;
  logic          pop_req = 1'b0;
  logic [AW-1:0] ret_addr;
  logic          ret_valid;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  exp_t sb [$];

  logic [AW-1:0] mdl [DP];
  int            mp = 0;

  always #5 clk = ~clk;

  ret_stack_ring u0 (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_addr(push_addr),
    .pop_req(pop_req), .ret_addr(ret_addr), .ret_valid(ret_valid)
  );

  task automatic report(input bit ok, input string tag, input logic [AW-1:0] act,
                        input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one operation per cycle, inputs changed on the falling edge.
  task automatic op(input bit p, input bit q, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    push_req  = p;
    pop_req   = q;
    push_addr = a;
    if (p) begin
      mdl[mp] = a;
      mp = (mp + 1) % DP;
    end else if (q) begin
      mp = (mp + DP - 1) % DP;
      sb.push_back('{addr: mdl[mp], tag: tag});
    end
  endtask

  task automatic idle();
    op(1'b0, 1'b0, '0, "idle");
  endtask

  // Monitor: compares every pop result against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && ret_valid) begin
      if (sb.size() == 0) begin
        report(1'b0, "R3 unexpected ret_valid", ret_addr, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        report(ret_addr === e.addr, e.tag, ret_addr, e.addr);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [AW-1:0] hold;
    repeat (3) @(negedge clk);
    report(ret_valid === 1'b0, "R1 valid in reset", AW'(ret_valid), '0);
    report(ret_addr === '0, "R1 addr in reset", ret_addr, '0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    @(negedge clk);
    report(ret_valid === 1'b0, "R1 valid after reset", AW'(ret_valid), '0);
    report(ret_addr === '0, "R1 addr after reset", ret_addr, '0);

    // R2: fill all entries, then unwind in LIFO order
    for (int i = 0; i < DP; i++) op(1'b1, 1'b0, AW'(13'h100 + i * 13'h11), "R2");
    for (int i = 0; i < DP; i++) op(1'b0, 1'b1, '0, "R2 LIFO");
    idle();

    // R5: pointer is at 0 again, pop wraps to the last entry
    op(1'b0, 1'b1, '0, "R5 underflow");
    op(1'b0, 1'b1, '0, "R5 second underflow");
    idle();
    // R3: address held while idle
    hold = ret_addr;
    repeat (3) idle();
    @(negedge clk);
    report(ret_addr === hold, "R3 hold", ret_addr, hold);

    // R3: back-to-back push/pop interleaving
    op(1'b1, 1'b0, 13'h0ABC, "R3");
    op(1'b0, 1'b1, '0, "R3 immediate pop");
    op(1'b1, 1'b0, 13'h0123, "R3");
    op(1'b1, 1'b0, 13'h0456, "R3");
    op(1'b0, 1'b1, '0, "R3 back-to-back pop");
    op(1'b0, 1'b1, '0, "R3 back-to-back pop");
    idle();

    // R4: ten pushes overwrite the two oldest
    for (int i = 0; i < DP + 2; i++) op(1'b1, 1'b0, AW'(13'h0800 + i), "R4");
    for (int i = 0; i < DP + 2; i++) op(1'b0, 1'b1, '0, "R4 overwrite");
    idle();

    // R8: full-width values
    op(1'b1, 1'b0, 13'h1FFF, "R8");
    op(1'b1, 1'b0, 13'h1000, "R8");
    op(1'b1, 1'b0, 13'h0001, "R8");
    op(1'b0, 1'b1, '0, "R8 low bit");
    op(1'b0, 1'b1, '0, "R8 top bit");
    op(1'b0, 1'b1, '0, "R8 all ones");
    idle();

    // R6: push and pop together, push only
    op(1'b1, 1'b1, 13'h0777, "R6");
    idle();
    @(negedge clk);
    report(ret_valid === 1'b0, "R6 no ret_valid", AW'(ret_valid), '0);
    op(1'b0, 1'b1, '0, "R6 pushed value");
    idle();

    // R7: entries survive a reset, only pointer clears
    for (int i = 0; i < DP; i++) op(1'b1, 1'b0, AW'(13'h1200 + i * 13'h3), "R7");
    idle();
    @(negedge clk);
    rst_n = 1'b0;
    mp = 0;
    @(negedge clk);
    report(ret_valid === 1'b0, "R1 valid in second reset", AW'(ret_valid), '0);
    report(ret_addr === '0, "R1 addr in second reset", ret_addr, '0);
    rst_n = 1'b1;
    op(1'b0, 1'b1, '0, "R7 entry kept");
    op(1'b0, 1'b1, '0, "R7 entry kept");
    idle();
    repeat (3) idle();

    report(sb.size() == 0, "R3 missing results", AW'(sb.size()), '0);
    finish_run();
  end

endmodule